// File: doc/BRIEF.md
# Nibble Accumulator Core

This block is a very small stored-program processor. Its data path and its only working register, the accumulator, are four bits wide. The program lives in a sixteen-entry internal store of bytes. Each byte holds an opcode in the upper nibble and a four-bit operand in the lower nibble. The operand is either an immediate value or an address in the store.

Before a run, a host writes the program one byte per clock through a loader port. While that port is active, the core stays in its reset state. When the loader lets go, execution starts at address 0. Each instruction runs through three clock phases in order: fetch, decode and execute.

The accumulator is driven onto an output port so that a display can show it. The core has six instructions: immediate load, store, add from memory, increment, clear and jump.

Top module: `nib_core`

## Requirements
- R1: A synchronous active-low reset, `rst_n` low at a rising edge, clears the accumulator to 0. It also returns the sequencer to fetch, so the first instruction after reset is the one at address 0. Store contents survive reset.
- R2: While `load_en` is high, each rising edge writes `load_data` into store entry `load_addr`. During the same time the accumulator reads 0 and the core does not execute. After `load_en` falls, execution starts at address 0.
- R3: Opcode 0x0 (immediate load) sets the accumulator to the low nibble of the instruction.
- R4: Opcode 0x1 (store) writes the byte {4'h0, accumulator} into the entry addressed by the operand. The accumulator is unchanged. When that entry is later executed, it behaves as an immediate load of the stored value.
- R5: Opcode 0x2 (add) sets the accumulator to (accumulator + low nibble of the entry at the operand address) mod 16. The upper nibble of that entry has no effect.
- R6: Opcode 0x6 (increment) sets the accumulator to (accumulator + 1) mod 16, so F becomes 0. Its operand is ignored.
- R7: Opcode 0x3 (clear) sets the accumulator to 0.
- R8: Opcode 0x4 (jump) makes the operand the address of the next instruction fetched.
- R9: Opcodes 0x5 and 0x7 to 0xF leave the accumulator unchanged, and execution continues at the next address.
- R10: Every instruction takes exactly three clock cycles. The accumulator changes only at the third rising edge after the fetch phase begins. The fetch address advances by one per instruction and wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Loader active: writes the store and holds the core in reset |
| load_addr | input | 4 | Store entry written by the loader |
| load_data | input | 8 | Byte written by the loader |
| acc_out | output | 4 | Current accumulator value |

## Verification
The only observable state is the accumulator, so an internal fault shows up through it. A wrong opcode decode or ALU result shows up at the execute edge of that same instruction. A wrong fetch address or a broken jump shows up one instruction later, when an unexpected byte is executed. A store that writes the wrong entry or the wrong nibble appears only when that entry is executed or added. For that reason the programs re-read stored data within a few instructions. A phase sequencer that skips or repeats a state moves the accumulator update off the third edge, and the mid-instruction sample catches this within three cycles.

// File: rtl/nib_pkg.sv
// Package nib_pkg
// Shared constants and types for the nibble accumulator core.
// Assumes a fixed four-bit opcode field in the upper part of each instruction.
package nib_pkg;
    localparam int NIB_W = 4;
    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_LDI = 4'h0;
    localparam logic [OPC_W-1:0] OPC_STO = 4'h1;
    localparam logic [OPC_W-1:0] OPC_ADM = 4'h2;
    localparam logic [OPC_W-1:0] OPC_CLA = 4'h3;
    localparam logic [OPC_W-1:0] OPC_JMP = 4'h4;
    localparam logic [OPC_W-1:0] OPC_INC = 4'h6;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2
    } phase_t;
endpackage

// File: rtl/nib_store.sv
// Module nib_store
// Program and data store: 2**ADDR_W entries of WORD_W bits.
// It has two asynchronous read ports (fetch and operand) and one write port.
// The loader write takes priority over a core write.
// Assumes the caller gates core writes to the execute phase.
module nib_store #(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [WORD_W-1:0] load_data,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [WORD_W-1:0] core_data,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [WORD_W-1:0] fetch_word,
    input  logic [ADDR_W-1:0] opnd_addr,
    output logic [WORD_W-1:0] opnd_word
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;

    // Pick the write source: the loader wins over the core.
    always_comb begin
        wr_en   = load_en | core_we;
        wr_addr = load_en ? load_addr : core_addr;
        wr_data = load_en ? load_data : core_data;
    end

    // Write one entry per cycle; contents are not reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Asynchronous reads for fetch and operand access.
    assign fetch_word = mem[fetch_addr];
    assign opnd_word  = mem[opnd_addr];

    // R2
    loader_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> mem[$past(load_addr)] == $past(load_data));
endmodule

// File: rtl/nib_alu.sv
// Module nib_alu
// Combinational decode and execute logic for one instruction.
// It produces the next accumulator value and two write enables.
// Assumes the outputs are used only in the execute phase.
module nib_alu
    import nib_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic [OPC_W-1:0]  opc,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] mem_nib,
    output logic [DATA_W-1:0] result,
    output logic              acc_we,
    output logic              mem_we,
    output logic              jump
);
    // Decode the opcode into a result and enables; unknown codes do nothing.
    always_comb begin
        result = acc;
        acc_we = 1'b0;
        mem_we = 1'b0;
        jump   = 1'b0;
        case (opc)
            OPC_LDI: begin result = operand;                 acc_we = 1'b1; end
            OPC_ADM: begin result = acc + mem_nib;           acc_we = 1'b1; end
            OPC_INC: begin result = acc + DATA_W'(1);        acc_we = 1'b1; end
            OPC_CLA: begin result = '0;                      acc_we = 1'b1; end
            OPC_STO: mem_we = 1'b1;
            OPC_JMP: jump   = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/nib_seq.sv
// Module nib_seq
// Three-phase sequencer holding the program counter and instruction register.
// FETCH latches the instruction and advances the PC. DECODE waits one cycle.
// EXEC applies a jump and returns to FETCH.
// Assumes hold (loader active) acts like reset.
module nib_seq
    import nib_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [WORD_W-1:0] fetch_word,
    input  logic              jump,
    output logic [ADDR_W-1:0] pc,
    output logic [WORD_W-1:0] ir,
    output logic              exec
);
    phase_t phase;

    // Advance phase, PC and IR; reset and hold return to fetch at address 0.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            phase <= PH_FETCH;
            pc    <= '0;
            ir    <= '0;
        end else begin
            case (phase)
                PH_FETCH: begin
                    ir    <= fetch_word;
                    pc    <= pc + ADDR_W'(1);
                    phase <= PH_DECODE;
                end
                PH_DECODE: phase <= PH_EXEC;
                default: begin
                    if (jump) pc <= ir[ADDR_W-1:0];
                    phase <= PH_FETCH;
                end
            endcase
        end
    end

    assign exec = (phase == PH_EXEC);

    // R10
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n || hold)
        (phase == PH_FETCH) |=> (phase == PH_DECODE));
    // R10
    exec_follows_chk: assert property (@(posedge clk) disable iff (!rst_n || hold)
        (phase == PH_DECODE) |=> exec);
    // R10
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n || hold)
        (phase == PH_FETCH) |=> pc == $past(pc) + ADDR_W'(1));
    // R8
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n || hold)
        (exec && jump) |=> pc == $past(ir[ADDR_W-1:0]));
endmodule

// File: rtl/nib_core.sv
// Module nib_core
// Top level of the nibble accumulator core. It ties together the store,
// the sequencer and the ALU, and owns the accumulator register.
// Assumes the program is written through the loader before execution starts.
module nib_core
    import nib_pkg::*;
#(
    parameter int DATA_W = NIB_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_en,
    input  logic [DATA_W-1:0]         load_addr,
    input  logic [OPC_W+DATA_W-1:0]   load_data,
    output logic [DATA_W-1:0]         acc_out
);
    localparam int ADDR_W = DATA_W;
    localparam int WORD_W = OPC_W + DATA_W;

    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] ir;
    logic [WORD_W-1:0] fetch_word;
    logic [WORD_W-1:0] opnd_word;
    logic              exec;
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] alu_res;
    logic              acc_we;
    logic              mem_we;
    logic              jump;

    nib_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .load_addr  (load_addr),
        .load_data  (load_data),
        .core_we    (exec && mem_we && !load_en),
        .core_addr  (ir[ADDR_W-1:0]),
        .core_data  ({{OPC_W{1'b0}}, acc}),
        .fetch_addr (pc),
        .fetch_word (fetch_word),
        .opnd_addr  (ir[ADDR_W-1:0]),
        .opnd_word  (opnd_word)
    );

    nib_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (load_en),
        .fetch_word (fetch_word),
        .jump       (jump),
        .pc         (pc),
        .ir         (ir),
        .exec       (exec)
    );

    nib_alu #(.DATA_W(DATA_W)) u_alu (
        .opc     (ir[WORD_W-1:DATA_W]),
        .acc     (acc),
        .operand (ir[DATA_W-1:0]),
        .mem_nib (opnd_word[DATA_W-1:0]),
        .result  (alu_res),
        .acc_we  (acc_we),
        .mem_we  (mem_we),
        .jump    (jump)
    );

    // Accumulator: cleared on reset or load, updated only in the execute phase.
    always_ff @(posedge clk) begin
        if (!rst_n || load_en) acc <= '0;
        else if (exec && acc_we) acc <= alu_res;
    end

    assign acc_out = acc;

    // R2
    load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> acc == '0);
    // R10
    acc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || load_en)
        !exec |=> $stable(acc));
    // R6
    inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n || load_en)
        (exec && ir[WORD_W-1:DATA_W] == OPC_INC) |=> acc == $past(acc) + DATA_W'(1));
    // R4
    store_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n || load_en)
        (exec && ir[WORD_W-1:DATA_W] == OPC_STO) |=> $stable(acc));
endmodule

// File: tb/nib_core_bench.sv
module nib_core_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic [3:0] acc_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] prog    [16];
    logic [7:0] mdl_mem [16];
    logic [3:0] mdl_acc;
    logic [3:0] mdl_pc;

    nib_core u_nib_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .acc_out   (acc_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: acc_out=%h expected=%h", req, act, exp);
        end
    endtask

    // Instruction-level model of the requirements.
    task automatic model_step();
        logic [7:0] w;
        w = mdl_mem[mdl_pc];
        mdl_pc = mdl_pc + 4'd1;
        case (w[7:4])
            4'h0: mdl_acc = w[3:0];
            4'h1: mdl_mem[w[3:0]] = {4'h0, mdl_acc};
            4'h2: mdl_acc = mdl_acc + mdl_mem[w[3:0]][3:0];
            4'h3: mdl_acc = 4'h0;
            4'h4: mdl_pc = w[3:0];
            4'h6: mdl_acc = mdl_acc + 4'd1;
            default: ;
        endcase
    endtask

    // Writes prog[] through the loader; returns at a falling edge with load_en low.
    task automatic load_prog();
        @(negedge clk);
        load_en = 1'b1;
        for (int i = 0; i < 16; i++) begin
            load_addr = 4'(i);
            load_data = prog[i];
            @(negedge clk);
            if (i == 15) check(acc_out, 4'h0, "R2 acc held at 0 during load");
        end
        load_en = 1'b0;
        for (int i = 0; i < 16; i++) mdl_mem[i] = prog[i];
        mdl_acc = 4'h0;
        mdl_pc  = 4'h0;
    endtask

    // Runs n instructions and checks the accumulator mid-instruction and after execute.
    task automatic run_steps(input int n, input string req);
        logic [3:0] prev;
        for (int k = 0; k < n; k++) begin
            prev = mdl_acc;
            model_step();
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            check(acc_out, prev, "R10 no change before execute edge");
            @(posedge clk);
            @(negedge clk);
            check(acc_out, mdl_acc, req);
        end
    endtask

    task automatic fill(input logic [7:0] v);
        for (int i = 0; i < 16; i++) prog[i] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: acc_out=%h expected=finished", acc_out);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(acc_out, 4'h0, "R1 reset clears acc");

        // R3 immediate load sweep; R10 wrap from 15 back to 0
        for (int i = 0; i < 16; i++) prog[i] = {4'h0, 4'(i)};
        load_prog();
        rst_n = 1'b1;
        run_steps(17, "R3 immediate load / R10 wrap");

        // R6 increment from every start value, including F to 0
        for (int a = 0; a < 16; a++) begin
            fill(8'h6A);
            prog[0] = {4'h0, 4'(a)};
            load_prog();
            run_steps(16, "R6 increment mod 16");
        end

        // R5 add: exhaustive over both operands; upper nibble of data ignored
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                fill(8'h70);
                prog[0]  = {4'h0, 4'(a)};
                prog[1]  = 8'h2F;
                prog[15] = {4'h9, 4'(b)};
                load_prog();
                run_steps(2, "R5 add mod 16");
            end
        end

        // R7 clear
        fill(8'h70);
        prog[0] = 8'h09; prog[1] = 8'h30;
        load_prog();
        run_steps(2, "R7 clear");

        // R4 store then execute the stored entry as an immediate load
        for (int a = 0; a < 16; a++) begin
            fill(8'h70);
            prog[0]  = {4'h0, 4'(a)};
            prog[1]  = 8'h1A;
            prog[2]  = 8'h30;
            prog[3]  = 8'h4A;
            prog[10] = 8'h3F;
            load_prog();
            run_steps(5, "R4 store / re-execute");
        end

        // R8 jump over increments
        fill(8'h60);
        prog[0] = 8'h01; prog[1] = 8'h45; prog[5] = 8'h07;
        load_prog();
        run_steps(4, "R8 jump target");

        // R9 undefined opcodes are no-ops and the PC advances
        for (int op = 5; op < 16; op++) begin
            if (op == 6) continue;
            fill(8'h70);
            prog[0] = 8'h09; prog[1] = {4'(op), 4'h3}; prog[2] = 8'h60;
            load_prog();
            run_steps(3, "R9 undefined opcode no-op");
        end

        // R1 reset mid-run: acc clears, memory kept, restart at address 0
        fill(8'h60);
        prog[0] = 8'h05;
        load_prog();
        run_steps(3, "R1 pre-reset run");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(acc_out, 4'h0, "R1 reset clears acc mid-run");
        rst_n = 1'b1;
        mdl_acc = 4'h0;
        mdl_pc  = 4'h0;
        run_steps(3, "R1 restart from address 0");

        // R2 loader mid-run: acc forced to 0, then restart at address 0
        run_steps(1, "R2 run before reload");
        prog[0] = 8'h0C;
        load_prog();
        run_steps(2, "R2 run after reload");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule